// File: doc/BRIEF.md
# Protection Domain Access Checker

This block decides whether a data access may go ahead when each page belongs to one of sixteen protection domains. Each page's translation entry holds a 4-bit domain key. A small fully associative translation cache keeps that key next to the virtual page number, so the check needs no page walk. One 32-bit rights register belongs to the running thread. It holds an access-disable bit and a write-disable bit for every domain. Software changes rights by writing this register, and no cached translation has to be touched.

Each request carries a virtual page number, an access kind and a flag that says whether the core is in 64-bit mode. One cycle later the block returns a registered response: a miss, an allow, or a fault with a 2-bit reason. Cache entries are filled through a separate port. A new page number goes into the entries in round-robin order. A page number that is already resident is updated in place.

Top module: `pk_guard`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the rights read port shows 0 and `rsp_valid` is 0. With rights at 0, every hit is allowed.
- R2: A rights write applies to requests presented from the next cycle onward. A request in the same cycle as the write is judged with the old rights. The read port shows the written value from the cycle after the write.
- R3: Domain k is controlled by rights bit 2k (access-disable) and bit 2k+1 (write-disable). No translation entry is refreshed when rights change.
- R4: A load (`req_kind` 00) in 64-bit mode faults with reason 01 when the access-disable bit of its domain is set.
- R5: A store (`req_kind` 01) in 64-bit mode faults with reason 01 when access-disable is set, whatever write-disable holds. Otherwise it faults with reason 10 when write-disable is set.
- R6: An instruction fetch (`req_kind` 10) that hits is always allowed. Kind 11 is treated the same way.
- R7: A hit with `req_long_mode` low is always allowed.
- R8: Each request gives exactly one response in the next cycle, with exactly one of `rsp_miss`, `rsp_allow` or `rsp_fault` set. `rsp_reason` is 00 unless `rsp_fault` is set, and then it is 01 or 10.
- R9: A request whose page number is not resident returns `rsp_miss` with allow and fault low.
- R10: A fill of a non-resident page number writes the entry under a round-robin pointer. The pointer starts at entry 0 after reset and advances by one per such fill, wrapping after entry 7. A lookup in the same cycle as a fill sees the cache contents from before the fill.
- R11: A fill of a page number that is already resident replaces that entry's key and leaves the round-robin pointer where it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rgt_wr_en | input | 1 | Write the rights register |
| rgt_wr_data | input | 32 | New rights value |
| rgt_rd_data | output | 32 | Current rights value |
| fill_en | input | 1 | Install or update a cache entry |
| fill_vpn | input | 20 | Page number to install |
| fill_key | input | 4 | Domain key of that page |
| req_valid | input | 1 | Access request present |
| req_vpn | input | 20 | Page number of the access |
| req_kind | input | 2 | 00 load, 01 store, 10 fetch, 11 treated as fetch |
| req_long_mode | input | 1 | 64-bit mode; enables the key check |
| rsp_valid | output | 1 | Response present |
| rsp_miss | output | 1 | Page number not resident |
| rsp_allow | output | 1 | Access permitted |
| rsp_fault | output | 1 | Access denied |
| rsp_reason | output | 2 | 00 none, 01 access-disabled, 10 write-disabled |

## Verification
The assertions assume that reset is released on a clock edge and that every input is known (never X) outside reset. They also assume that two fills never install the same page number into two entries, which R11 rules out as long as fills go through the port. The bench drives every input from time zero and releases reset away from the active edge. It changes inputs only on falling edges and reuses page numbers only to exercise in-place update. The bench's scoreboard keeps its own copy of the cache slots, the pointer and the rights. Expected responses come from that copy in the cycle the request is driven.

// File: rtl/pk_guard_pkg.sv
package pk_guard_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    WHY_NONE   = 2'b00,
    WHY_NOACC  = 2'b01,
    WHY_NOWR   = 2'b10
  } fault_why_e;

  typedef struct packed {
    logic       valid;
    logic       miss;
    logic       allow;
    logic       fault;
    fault_why_e why;
  } verdict_t;
endpackage

// File: rtl/pk_rights_reg.sv
module pk_rights_reg #(
  parameter int DOMAINS = 16,
  localparam int W = 2 * DOMAINS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rights
);
  logic [W-1:0] rights_q, rights_d;

  always_comb begin
    rights_d = rights_q;
    if (wr_en) rights_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rights_q <= '0;
    else if (wr_en)  rights_q <= rights_d;
  end

  assign rights = rights_q;
endmodule

// File: rtl/pk_key_tlb.sv
module pk_key_tlb #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int KEY_W   = 4,
  localparam int PTR_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [KEY_W-1:0] fill_key,
  input  logic [VPN_W-1:0] look_vpn,
  output logic             look_hit,
  output logic [KEY_W-1:0] look_key
);
  logic [ENTRIES-1:0] val_q;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [KEY_W-1:0]   key_q [ENTRIES];
  logic [PTR_W-1:0]   ptr_q, ptr_d;
  logic [ENTRIES-1:0] look_match, fill_match, wr_sel;
  logic               fill_resident;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign look_match[i] = val_q[i] && (vpn_q[i] == look_vpn);
    assign fill_match[i] = val_q[i] && (vpn_q[i] == fill_vpn);
  end

  assign fill_resident = |fill_match;
  assign look_hit      = |look_match;

  always_comb begin
    look_key = '0;
    for (int i = 0; i < ENTRIES; i++)
      look_key = look_key | (key_q[i] & {KEY_W{look_match[i]}});
  end

  always_comb begin
    wr_sel = '0;
    ptr_d  = ptr_q;
    if (fill_en) begin
      if (fill_resident) begin
        wr_sel = fill_match;
      end else begin
        for (int i = 0; i < ENTRIES; i++)
          wr_sel[i] = (ptr_q == PTR_W'(i));
        ptr_d = (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ptr_q <= '0;
    else if (fill_en)  ptr_q <= ptr_d;
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q[i] <= 1'b0;
        vpn_q[i] <= '0;
        key_q[i] <= '0;
      end else if (wr_sel[i]) begin
        val_q[i] <= 1'b1;
        vpn_q[i] <= fill_vpn;
        key_q[i] <= fill_key;
      end
    end
  end
endmodule

// File: rtl/pk_perm_eval.sv
module pk_perm_eval
  import pk_guard_pkg::*;
#(
  parameter int KEY_W = 4,
  localparam int DOMAINS = 1 << KEY_W,
  localparam int W = 2 * DOMAINS
) (
  input  logic             hit,
  input  logic [KEY_W-1:0] key,
  input  logic [1:0]       kind,
  input  logic             long_mode,
  input  logic [W-1:0]     rights,
  output logic             allow,
  output logic             fault,
  output fault_why_e       why
);
  logic no_acc, no_wr, is_load, is_store, checked;

  assign no_acc   = rights[{key, 1'b0}];
  assign no_wr    = rights[{key, 1'b1}];
  assign is_load  = (kind == ACC_LOAD);
  assign is_store = (kind == ACC_STORE);
  assign checked  = hit && long_mode && (is_load || is_store);

  always_comb begin
    why = WHY_NONE;
    if (checked) begin
      if (no_acc)                why = WHY_NOACC;
      else if (is_store && no_wr) why = WHY_NOWR;
    end
    fault = (why != WHY_NONE);
    allow = hit && !fault;
  end
endmodule

// File: rtl/pk_guard.sv
module pk_guard
  import pk_guard_pkg::*;
#(
  parameter int VPN_W       = 20,
  parameter int TLB_ENTRIES = 8,
  parameter int KEY_W       = 4,
  localparam int RIGHTS_W   = 2 * (1 << KEY_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rgt_wr_en,
  input  logic [RIGHTS_W-1:0] rgt_wr_data,
  output logic [RIGHTS_W-1:0] rgt_rd_data,
  input  logic                fill_en,
  input  logic [VPN_W-1:0]    fill_vpn,
  input  logic [KEY_W-1:0]    fill_key,
  input  logic                req_valid,
  input  logic [VPN_W-1:0]    req_vpn,
  input  logic [1:0]          req_kind,
  input  logic                req_long_mode,
  output logic                rsp_valid,
  output logic                rsp_miss,
  output logic                rsp_allow,
  output logic                rsp_fault,
  output logic [1:0]          rsp_reason
);
  logic [RIGHTS_W-1:0] rights;
  logic                hit;
  logic [KEY_W-1:0]    key;
  logic                ev_allow, ev_fault;
  fault_why_e          ev_why;
  verdict_t            rsp_d, rsp_q;

  pk_rights_reg #(.DOMAINS(1 << KEY_W)) u_rights (
    .clk(clk), .rst_n(rst_n), .wr_en(rgt_wr_en), .wr_data(rgt_wr_data), .rights(rights)
  );

  pk_key_tlb #(.ENTRIES(TLB_ENTRIES), .VPN_W(VPN_W), .KEY_W(KEY_W)) u_tlb (
    .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_key(fill_key),
    .look_vpn(req_vpn), .look_hit(hit), .look_key(key)
  );

  pk_perm_eval #(.KEY_W(KEY_W)) u_eval (
    .hit(hit), .key(key), .kind(req_kind), .long_mode(req_long_mode), .rights(rights),
    .allow(ev_allow), .fault(ev_fault), .why(ev_why)
  );

  always_comb begin
    rsp_d = '0;
    if (req_valid) begin
      rsp_d.valid = 1'b1;
      rsp_d.miss  = !hit;
      rsp_d.allow = ev_allow;
      rsp_d.fault = ev_fault;
      rsp_d.why   = ev_why;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_q <= '0;
    else        rsp_q <= rsp_d;
  end

  assign rgt_rd_data = rights;
  assign rsp_valid   = rsp_q.valid;
  assign rsp_miss    = rsp_q.miss;
  assign rsp_allow   = rsp_q.allow;
  assign rsp_fault   = rsp_q.fault;
  assign rsp_reason  = rsp_q.why;
endmodule

// File: rtl/pk_guard_chk.sv
module pk_guard_chk #(
  parameter int RW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rgt_wr_en,
  input logic [RW-1:0] rgt_wr_data,
  input logic [RW-1:0] rgt_rd_data,
  input logic          req_valid,
  input logic [1:0]    req_kind,
  input logic          req_long_mode,
  input logic          rsp_valid,
  input logic          rsp_miss,
  input logic          rsp_allow,
  input logic          rsp_fault,
  input logic [1:0]    rsp_reason
);
  // R2
  rights_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rgt_wr_en |=> (rgt_rd_data == $past(rgt_wr_data)));
  // R2
  rights_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rgt_wr_en |=> $stable(rgt_rd_data));
  // R8
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R8
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R8
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_miss, rsp_allow, rsp_fault}) == 1));
  // R8
  quiet_reason_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_fault |-> (rsp_reason == 2'b00));
  // R8
  fault_reason_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_reason == 2'b01 || rsp_reason == 2'b10));
  // R6
  fetch_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind[1]) |=> !rsp_fault);
  // R7
  legacy_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_long_mode) |=> !rsp_fault);
endmodule

bind pk_guard pk_guard_chk #(.RW(RIGHTS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rgt_wr_en(rgt_wr_en), .rgt_wr_data(rgt_wr_data),
  .rgt_rd_data(rgt_rd_data), .req_valid(req_valid), .req_kind(req_kind),
  .req_long_mode(req_long_mode), .rsp_valid(rsp_valid), .rsp_miss(rsp_miss),
  .rsp_allow(rsp_allow), .rsp_fault(rsp_fault), .rsp_reason(rsp_reason)
);

// File: tb/pk_guard_bench.sv
`timescale 1ns/1ps
module pk_guard_bench;
  typedef struct {
    logic       miss;
    logic       allow;
    logic       fault;
    logic [1:0] why;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rgt_wr_en;
  logic [31:0] rgt_wr_data, rgt_rd_data;
  logic        fill_en;
  logic [19:0] fill_vpn;
  logic [3:0]  fill_key;
  logic        req_valid;
  logic [19:0] req_vpn;
  logic [1:0]  req_kind;
  logic        req_long_mode;
  logic        rsp_valid, rsp_miss, rsp_allow, rsp_fault;
  logic [1:0]  rsp_reason;

  int checks = 0, fails = 0;
  bit done = 0;
  exp_t sb[$];

  logic [19:0] m_vpn [8];
  logic [3:0]  m_key [8];
  bit          m_val [8];
  int          m_ptr;
  logic [31:0] m_rights;

  always #2.5 clk = ~clk;

  pk_guard u_pk_guard (
    .clk(clk), .rst_n(rst_n), .rgt_wr_en(rgt_wr_en), .rgt_wr_data(rgt_wr_data),
    .rgt_rd_data(rgt_rd_data), .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_key(fill_key),
    .req_valid(req_valid), .req_vpn(req_vpn), .req_kind(req_kind),
    .req_long_mode(req_long_mode), .rsp_valid(rsp_valid), .rsp_miss(rsp_miss),
    .rsp_allow(rsp_allow), .rsp_fault(rsp_fault), .rsp_reason(rsp_reason)
  );

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %s expected %s", tag, act, exp);
    end
  endtask

  function automatic exp_t predict(input logic [19:0] vpn, input logic [1:0] kind,
                                   input logic lm, input string tag);
    exp_t e;
    int slot = -1;
    e.miss = 0; e.allow = 0; e.fault = 0; e.why = 2'b00; e.tag = tag;
    for (int i = 0; i < 8; i++) if (m_val[i] && m_vpn[i] == vpn) slot = i;
    if (slot < 0) begin
      e.miss = 1;
    end else begin
      logic ad, wd;
      ad = m_rights[2 * m_key[slot]];
      wd = m_rights[2 * m_key[slot] + 1];
      if (lm && kind == 2'b00 && ad) e.why = 2'b01;
      else if (lm && kind == 2'b01 && ad) e.why = 2'b01;
      else if (lm && kind == 2'b01 && wd) e.why = 2'b10;
      e.fault = (e.why != 2'b00);
      e.allow = !e.fault;
    end
    return e;
  endfunction

  function automatic void model_fill(input logic [19:0] vpn, input logic [3:0] key);
    int slot = -1;
    for (int i = 0; i < 8; i++) if (m_val[i] && m_vpn[i] == vpn) slot = i;
    if (slot >= 0) m_key[slot] = key;
    else begin
      m_val[m_ptr] = 1; m_vpn[m_ptr] = vpn; m_key[m_ptr] = key;
      m_ptr = (m_ptr + 1) % 8;
    end
  endfunction

  task automatic idle();
    @(negedge clk);
    req_valid = 0; fill_en = 0; rgt_wr_en = 0;
  endtask

  task automatic access(input logic [19:0] vpn, input logic [1:0] kind, input logic lm,
                        input string tag);
    @(negedge clk);
    req_valid = 1; req_vpn = vpn; req_kind = kind; req_long_mode = lm;
    fill_en = 0; rgt_wr_en = 0;
    sb.push_back(predict(vpn, kind, lm, tag));
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [3:0] key);
    @(negedge clk);
    req_valid = 0; rgt_wr_en = 0;
    fill_en = 1; fill_vpn = vpn; fill_key = key;
    model_fill(vpn, key);
  endtask

  task automatic write_rights(input logic [31:0] v);
    @(negedge clk);
    req_valid = 0; fill_en = 0;
    rgt_wr_en = 1; rgt_wr_data = v;
    m_rights = v;
  endtask

  task automatic write_and_access(input logic [31:0] v, input logic [19:0] vpn,
                                  input logic [1:0] kind, input string tag);
    @(negedge clk);
    fill_en = 0;
    rgt_wr_en = 1; rgt_wr_data = v;
    req_valid = 1; req_vpn = vpn; req_kind = kind; req_long_mode = 1;
    sb.push_back(predict(vpn, kind, 1'b1, tag));
    m_rights = v;
  endtask

  task automatic fill_and_access(input logic [19:0] vpn, input logic [3:0] key, input string tag);
    @(negedge clk);
    rgt_wr_en = 0;
    fill_en = 1; fill_vpn = vpn; fill_key = key;
    req_valid = 1; req_vpn = vpn; req_kind = 2'b00; req_long_mode = 1;
    sb.push_back(predict(vpn, 2'b00, 1'b1, tag));
    model_fill(vpn, key);
  endtask

  // scoreboard monitor: responses appear one cycle after the request edge
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        check(0, "R8 unexpected response", "rsp_valid=1", "no response");
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(rsp_miss == e.miss && rsp_allow == e.allow && rsp_fault == e.fault &&
              rsp_reason == e.why, e.tag,
              $sformatf("miss=%0b allow=%0b fault=%0b why=%02b", rsp_miss, rsp_allow, rsp_fault, rsp_reason),
              $sformatf("miss=%0b allow=%0b fault=%0b why=%02b", e.miss, e.allow, e.fault, e.why));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(0, "watchdog", "timeout", "completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_val[i] = 0; m_vpn[i] = '0; m_key[i] = '0; end
    m_ptr = 0; m_rights = '0;
    rst_n = 0; rgt_wr_en = 0; rgt_wr_data = '0; fill_en = 0; fill_vpn = '0; fill_key = '0;
    req_valid = 0; req_vpn = '0; req_kind = '0; req_long_mode = 0;
    repeat (3) @(negedge clk);
    check(rgt_rd_data == 0 && rsp_valid == 0, "R1 reset state",
          $sformatf("rd=%h v=%0b", rgt_rd_data, rsp_valid), "rd=00000000 v=0");
    rst_n = 1;
    @(negedge clk);
    check(rgt_rd_data == 0 && rsp_valid == 0, "R1 after release",
          $sformatf("rd=%h v=%0b", rgt_rd_data, rsp_valid), "rd=00000000 v=0");

    access(20'h999, 2'b00, 1, "R9 miss on empty cache");
    for (int i = 0; i < 8; i++) fill(20'h100 + 20'(i), 4'(i + 2));
    access(20'h101, 2'b01, 1, "R1 store allowed with zero rights");
    access(20'h107, 2'b00, 1, "R1 load allowed with zero rights");
    access(20'h555, 2'b01, 1, "R9 miss after fills");

    // domain 2 AD+WD (bits 4,5), domain 3 AD (bit 6), domain 5 WD (bit 11)
    write_rights(32'h0000_0870);
    idle();
    check(rgt_rd_data == 32'h0000_0870, "R2 read port",
          $sformatf("%h", rgt_rd_data), "00000870");
    access(20'h101, 2'b00, 1, "R4 load in access-disabled domain 3");
    access(20'h101, 2'b01, 1, "R5 store in access-disabled domain 3");
    access(20'h103, 2'b00, 1, "R3 load in write-disabled domain 5");
    access(20'h103, 2'b01, 1, "R5 store in write-disabled domain 5");
    access(20'h100, 2'b01, 1, "R5 AD wins over WD in domain 2");
    access(20'h101, 2'b10, 1, "R6 fetch bypasses key check");
    access(20'h101, 2'b11, 1, "R6 reserved kind bypasses key check");
    access(20'h103, 2'b01, 0, "R7 check off outside 64-bit mode");
    access(20'h104, 2'b01, 1, "R3 neighbour domain 6 unaffected");

    // add WD for domain 4 (bit 9); same-cycle store sees old rights
    write_and_access(32'h0000_0A70, 20'h102, 2'b01, "R2 same-cycle request uses old rights");
    access(20'h102, 2'b01, 1, "R2 next-cycle request uses new rights");
    idle();
    check(rgt_rd_data == 32'h0000_0A70, "R2 read port after second write",
          $sformatf("%h", rgt_rd_data), "00000A70");

    fill_and_access(20'h200, 4'd7, "R10 lookup in fill cycle sees old contents");
    access(20'h100, 2'b00, 1, "R10 round-robin evicted entry 0");
    access(20'h200, 2'b00, 1, "R10 new entry hits");
    access(20'h101, 2'b00, 1, "R10 entry 1 still resident");

    fill(20'h103, 4'd3);
    access(20'h103, 2'b00, 1, "R11 in-place key update");
    fill(20'h300, 4'd0);
    access(20'h101, 2'b00, 1, "R11 pointer unchanged, entry 1 evicted");
    access(20'h102, 2'b01, 1, "R11 entry 2 still resident");
    access(20'h300, 2'b01, 1, "R10 wrap-around fill hits");
    idle();
    idle();
    check(sb.size() == 0, "R8 every request answered",
          $sformatf("%0d pending", sb.size()), "0 pending");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule